// File: doc/BRIEF.md
# Two-Format 16-bit Processor Core

This core runs a two-format instruction stream with two working registers: a data register that always feeds the first ALU operand, and an address register that both holds constants and addresses data memory. It also holds a program counter. It fetches from an external instruction ROM through `rom_addr` and `instr`. It reads and writes an external data RAM whose address is always the low bits of the address register. Both memories are expected to answer combinationally within the same cycle.

A word with bit 15 clear loads its low 15 bits into the address register. A word with bit 15 set is a compute word. It chooses the second ALU operand, sets the six ALU control bits, enables any mix of three destinations, and carries a three-bit jump mask. The mask is tested against the sign and zero of the result produced in that same cycle. Every register update and the RAM write take effect on one clock edge.

Top module: `cpu16_core`

## Requirements
- R1: While reset is held, the PC is 0 and the address and data registers are 0, so a first instruction of "RAM = data register" writes 0 to address 0.
- R2: A word with bit 15 = 0 loads {0, instr[14:0]} into the address register, never asserts the RAM write, and advances the PC by 1.
- R3: In a compute word, bit 12 picks the second ALU operand: 0 selects the address register and 1 selects the RAM word at the address register. The first operand is always the data register.
- R4: Bits 11..6 are, in order, zero-x, invert-x, zero-y, invert-y, add (1) or bitwise AND (0), and invert-output. They are applied in that sequence.
- R5: Destination bits 5, 4 and 3 independently enable writing the ALU result to the address register, the data register and RAM. Any combination is legal, including none.
- R6: `mem_we` is 1 only for a compute word with bit 3 set. The write data is the ALU result, and the write address is the address register as it stood before that cycle's update.
- R7: Jump bits 2, 1 and 0 test the result for negative (bit 15 set), zero, and positive (neither). The jump is taken when any enabled test holds.
- R8: A taken jump loads the PC from the address register as it stood before the instruction, even when the same word also writes that register. Otherwise the PC advances by 1.
- R9: `mem_addr` always shows the low ADDR_W bits of the current address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | PC_W | Instruction fetch address (the PC) |
| instr | input | 16 | Instruction word at rom_addr |
| mem_addr | output | ADDR_W | Data RAM address (address register) |
| mem_rdata | input | 16 | Data RAM read word at mem_addr |
| mem_wdata | output | 16 | Data RAM write word (ALU result) |
| mem_we | output | 1 | Data RAM write enable |

## Verification
A single program runs the core against a behavioural ROM and RAM, and a scoreboard checks PC, write enable, address and write data on every cycle.

- **Constants.** Constant words with bit 3 set in the payload show that the constant format never writes RAM. The 0x7FFF constant shows zero-extension.
- **ALU.** Compute words use both operand selections and several ALU codes (increment, subtract, sum, decrement, invert, constant 0 and -1). These separate the six control bits from one another.
- **Jumps.** Jump masks are paired with positive, zero and negative results, so each test bit is seen both taken and not taken.
- **Simultaneous updates.** Words that write the address register while also writing RAM or jumping tell the old address-register value apart from the new one.

// File: rtl/cpu16_core.sv
module cpu16_core #(
  parameter int PC_W   = 15,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   rom_addr,
  input  logic [15:0]       instr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       mem_wdata,
  output logic              mem_we
);

  logic [PC_W-1:0] pc_q;
  logic [15:0]     a_q, d_q;

  logic        is_cmp;
  logic [5:0]  fn;
  logic [15:0] opx, opy, x0, x1, y0, y1, raw, res;
  logic        res_zero, res_neg, take;

  assign is_cmp = instr[15];
  assign fn     = instr[11:6];

  assign opx = d_q;
  assign opy = instr[12] ? mem_rdata : a_q;
  assign x0  = fn[5] ? 16'h0000 : opx;
  assign x1  = fn[4] ? ~x0 : x0;
  assign y0  = fn[3] ? 16'h0000 : opy;
  assign y1  = fn[2] ? ~y0 : y0;
  assign raw = fn[1] ? (x1 + y1) : (x1 & y1);
  assign res = fn[0] ? ~raw : raw;

  assign res_zero = (res == 16'h0000);
  assign res_neg  = res[15];
  assign take = is_cmp & ((instr[2] & res_neg) | (instr[1] & res_zero) |
                          (instr[0] & ~res_neg & ~res_zero));

  assign rom_addr  = pc_q;
  assign mem_addr  = a_q[ADDR_W-1:0];
  assign mem_wdata = res;
  assign mem_we    = is_cmp & instr[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      pc_q <= take ? a_q[PC_W-1:0] : pc_q + 1'b1;
      if (!is_cmp)        a_q <= {1'b0, instr[14:0]};
      else if (instr[5])  a_q <= res;
      if (is_cmp && instr[4]) d_q <= res;
    end
  end

  // R2
  const_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr[15] |=> a_q == {1'b0, $past(instr[14:0])});

  // R5
  dreg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15] && instr[4]) |=> d_q == $past(res));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc_q == $past(a_q[PC_W-1:0]));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15] && instr[2:0] == 3'b000) |=> pc_q == $past(pc_q) + 1'b1);

  // R6
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr[15] && $past(rst_n)) |-> !mem_we);

endmodule

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] rom_addr;
  logic [15:0] instr;
  logic [14:0] mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we;

  logic [15:0] rom [0:63];
  logic [15:0] ram [0:32767];

  always #5 clk = ~clk;

  cpu16_core u0 (.clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .instr(instr),
                 .mem_addr(mem_addr), .mem_rdata(mem_rdata),
                 .mem_wdata(mem_wdata), .mem_we(mem_we));

  assign instr     = rom[rom_addr[5:0]];
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  typedef struct packed {
    logic [14:0] pc;
    logic        we;
    logic [14:0] addr;
    logic [15:0] wd;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0;
  bit   go = 0, done = 0;
  string tags[$];

  function automatic logic [15:0] cw(input logic a, input logic [5:0] c,
                                     input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  task automatic push(input int pc, input bit we, input int addr, input int wd,
                      input string tag);
    exp_t e;
    e.pc = pc[14:0]; e.we = we; e.addr = addr[14:0]; e.wd = wd[15:0];
    sb.push_back(e);
    tags.push_back(tag);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
    rom[0]  = cw(0, 6'b001100, 3'b001, 3'b000);
    rom[1]  = 16'h7FFF;
    rom[2]  = cw(0, 6'b110000, 3'b001, 3'b000);
    rom[3]  = 16'd5;
    rom[4]  = cw(0, 6'b110000, 3'b010, 3'b000);
    rom[5]  = 16'd100;
    rom[6]  = cw(0, 6'b001100, 3'b001, 3'b000);
    rom[7]  = cw(1, 6'b110111, 3'b010, 3'b000);
    rom[8]  = cw(0, 6'b010011, 3'b101, 3'b000);
    rom[9]  = 16'd16;
    rom[10] = cw(0, 6'b001100, 3'b000, 3'b100);
    rom[11] = cw(0, 6'b001100, 3'b000, 3'b010);
    rom[12] = cw(0, 6'b001100, 3'b000, 3'b001);
    rom[16] = 16'd20;
    rom[17] = cw(0, 6'b111010, 3'b000, 3'b010);
    rom[18] = cw(0, 6'b111010, 3'b000, 3'b100);
    rom[20] = 16'd24;
    rom[21] = cw(0, 6'b110111, 3'b100, 3'b111);
    rom[24] = cw(0, 6'b110000, 3'b001, 3'b000);
    rom[25] = cw(0, 6'b101010, 3'b000, 3'b001);
    rom[26] = cw(0, 6'b101010, 3'b000, 3'b100);
    rom[27] = 16'd30;
    rom[28] = cw(0, 6'b101010, 3'b000, 3'b010);
    rom[30] = cw(0, 6'b000010, 3'b111, 3'b000);
    rom[31] = cw(0, 6'b001110, 3'b001, 3'b000);
    rom[32] = cw(0, 6'b000000, 3'b000, 3'b000);
    rom[33] = cw(0, 6'b001101, 3'b001, 3'b000);
    rom[34] = 16'd34;
    rom[35] = cw(0, 6'b101010, 3'b000, 3'b111);
  end

  // driver: expected trace, one item per executed cycle
  initial begin
    push(0,  1, 0,      0,      "R1 cleared regs write");
    push(1,  0, 0,      0,      "R2 constant");
    push(2,  1, 15'h7FFF, 16'h7FFF, "R2 zero-extend");
    push(3,  0, 15'h7FFF, 0,    "R2 constant no write");
    push(4,  0, 5,      0,      "R3 y=A");
    push(5,  0, 5,      0,      "R2 constant");
    push(6,  1, 100,    5,      "R6 write data");
    push(7,  0, 100,    0,      "R3 y=M");
    push(8,  1, 100,    16'hFFA2, "R6 old address R4 subtract");
    push(9,  0, 15'h7FA2, 0,    "R9 address from A");
    push(10, 0, 16,     0,      "R7 neg not taken");
    push(11, 0, 16,     0,      "R7 zero not taken");
    push(12, 0, 16,     0,      "R7 pos taken");
    push(16, 0, 16,     0,      "R8 jump target");
    push(17, 0, 20,     0,      "R7 zero on -1 not taken");
    push(18, 0, 20,     0,      "R7 neg taken");
    push(20, 0, 20,     0,      "R8 jump target");
    push(21, 0, 24,     0,      "R8 jump old A");
    push(24, 1, 25,     25,     "R5 A written");
    push(25, 0, 25,     0,      "R7 pos on zero not taken");
    push(26, 0, 25,     0,      "R7 neg on zero not taken");
    push(27, 0, 25,     0,      "R2 constant");
    push(28, 0, 30,     0,      "R7 zero taken");
    push(30, 1, 30,     36,     "R5 all dests R4 add");
    push(31, 1, 36,     35,     "R5 R4 decrement");
    push(32, 0, 36,     0,      "R5 no dest");
    push(33, 1, 36,     16'hFFDB, "R4 invert");
  end

  // reset and monitor
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", rom_addr, 0);
    chk("R1 addr", mem_addr, 0);
    rst_n = 1;
    while (sb.size() > 0) begin
      exp_t e;
      string t;
      e = sb.pop_front();
      t = tags.pop_front();
      chk({t, " pc"}, rom_addr, e.pc);
      chk({t, " we"}, mem_we, e.we);
      chk({t, " addr"}, mem_addr, e.addr);
      if (e.we) chk({t, " wdata"}, mem_wdata, e.wd);
      @(negedge clk);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule